// File: doc/BRIEF.md
# Multi-Lane Receive Lock Controller

This controller sits on the receive side of a serial link that carries one 32-bit parallel word over two or four lanes, each lane with an embedded clock marker. Once per frame slot the recovery logic pulses `frame_tick` and reports on `lane_mark` which lanes showed a good marker in that slot. From these reports the controller decides when the recovered words may be trusted. It raises `lock` and lets words through to `word_out` only while every active lane is locked.

Acquisition always starts on lane 0, the master lane. After the master lane has locked, the remaining lanes are counted. Whether the link runs on two or four lanes is worked out from the marker history alone, with no training pattern. One missed marker on any active lane drops `lock` in the cycle it is reported, and acquisition then starts over on lane 0. A power-down input holds the controller idle and turns off the output drivers. A separate output-enable input controls the drive enable for the data and recovered-clock pins.

Top module: `lane_lock_ctrl`

## Requirements
- R1: `lock` is high only after the master lane has locked and then every active secondary lane has locked. A lane counts as locked after a run of consecutive ticks with its `lane_mark` bit set: 8 for lane 0, 4 for lanes 1 to 3.
- R2: `word_valid` equals `lock`. `word_out` equals `rx_word` while `lock` is high and is all zeros otherwise.
- R3: While locked, a tick on which any active lane's `lane_mark` bit is 0 pulls `lock` low in that same cycle, and `lock` stays low until a complete new acquisition.
- R4: Acquisition restarts from an empty count on lane 0. A gap in the lane 0 run restarts the count at zero. Secondary runs begin only on the tick after lane 0 reaches its run of 8, so a fresh lock with all lanes good takes 12 ticks.
- R5: The frame counter starts at master lock. `quad_mode`=1 (four lanes) is chosen if lanes 2 and 3 both complete their runs by frame 16. Otherwise `quad_mode`=0 (two lanes), and lock is then allowed no earlier than frame 16. `quad_mode` holds its value while locked.
- R6: If lane 0 misses a marker during secondary acquisition, the controller goes back to acquiring the master lane.
- R7: `pwr_dn`=1 forces `lock` and `out_drive_en` low in the same cycle. After release, a full relock per R4 is needed.
- R8: `out_drive_en` equals `out_en` AND NOT `pwr_dn`. It is the tri-state enable for the data and recovered-clock outputs and does not affect `lock`.
- R9: In two-lane mode, marker misses on lanes 2 and 3 do not affect `lock`.
- R10: After reset, `lock`, `word_valid` and `quad_mode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down request, active high |
| out_en | input | 1 | Output drive enable request |
| frame_tick | input | 1 | One-cycle pulse per frame slot |
| lane_mark | input | 4 | Per-lane good-marker flags, sampled on `frame_tick` |
| rx_word | input | 32 | Recovered parallel word |
| lock | output | 1 | All active lanes locked |
| quad_mode | output | 1 | 1 = four lanes, 0 = two lanes |
| word_valid | output | 1 | `word_out` carries a valid word |
| word_out | output | 32 | Gated parallel word |
| out_drive_en | output | 1 | Tri-state enable for data and clock outputs |

## Verification
Frame 16 after master lock can be both the frame that completes the four-lane detection and the frame that closes the window and lets a two-lane lock through. Its neighbour is the frame that would complete the detection one slot too late. The bench places the completion of the lane 2 and lane 3 runs exactly on frame 16, and in a second pass on frame 17. It expects a four-lane lock in the first case and a two-lane lock at frame 16 in the second. A second coincidence is a power-down request arriving in the same cycle as a missed marker while locked. The bench expects `lock` and the drive enable both low in that cycle and a full 12-tick relock afterwards.

// File: rtl/lockctl_pkg.sv
package lockctl_pkg;

  localparam int LANES = 4;

  typedef enum logic [1:0] {
    LS_PWRDN  = 2'd0,
    LS_ACQ_M  = 2'd1,
    LS_ACQ_S  = 2'd2,
    LS_LOCKED = 2'd3
  } lk_state_e;

  // consecutive-run update, saturating at the limit
  function automatic int run_step(input int cur, input logic mark, input int limit);
    if (!mark) return 0;
    if (cur + 1 > limit) return limit;
    return cur + 1;
  endfunction

  // true when the run reaches the limit with this tick
  function automatic logic run_done(input int cur, input logic mark, input int limit);
    return mark && (cur + 1 >= limit);
  endfunction

  // frame window count, saturating one past the window
  function automatic int win_step(input int cur, input int win);
    if (cur >= win + 1) return win + 1;
    return cur + 1;
  endfunction

  function automatic logic [LANES-1:0] active_set(input logic quad);
    return quad ? 4'b1111 : 4'b0011;
  endfunction

endpackage

// File: rtl/lane_run_ctr.sv
module lane_run_ctr
  import lockctl_pkg::*;
#(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic mark,
  output logic done_nxt
);

  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (!en)    run_q <= '0;
    else if (tick)   run_q <= CW'(run_step(int'(run_q), mark, LIMIT));
  end

  assign done_nxt = en && tick && run_done(int'(run_q), mark, LIMIT);

  // R1
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= LIMIT);

  // R4
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (run_q == '0));

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import lockctl_pkg::*;
#(
  parameter int QUAD_WIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_dn,
  input  logic             tick,
  input  logic [LANES-1:0] lane_mark,
  input  logic [LANES-1:0] done_nxt,
  output lk_state_e        state_q,
  output logic [LANES-1:0] lane_en,
  output logic             quad_q,
  output logic             lock_o,
  output logic             ev_fail,
  output logic             ev_lock_enter
);

  localparam int WW = $clog2(QUAD_WIN + 2);

  lk_state_e       state_d;
  logic [WW-1:0]   win_q;
  logic            qseen_q;
  int              win_nx;
  logic            in_win, win_over, quad_hit, qseen_nx, sec_ready, miss_act;

  always_comb begin
    win_nx    = win_step(int'(win_q), QUAD_WIN);
    in_win    = (win_nx <= QUAD_WIN);
    win_over  = (win_nx >= QUAD_WIN);
    quad_hit  = done_nxt[2] && done_nxt[3] && in_win;
    qseen_nx  = qseen_q || quad_hit;
    sec_ready = done_nxt[1] && (qseen_nx ? (done_nxt[2] && done_nxt[3]) : win_over);
    miss_act  = tick && (|(active_set(quad_q) & ~lane_mark));
  end

  assign ev_lock_enter = (state_q == LS_ACQ_S) && tick && lane_mark[0] && sec_ready;
  assign ev_fail = ((state_q == LS_ACQ_S) && tick && !lane_mark[0]) ||
                   ((state_q == LS_LOCKED) && miss_act);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      LS_PWRDN:  state_d = LS_ACQ_M;
      LS_ACQ_M:  if (done_nxt[0]) state_d = LS_ACQ_S;
      LS_ACQ_S: begin
        if (tick && !lane_mark[0]) state_d = LS_ACQ_M;
        else if (ev_lock_enter)    state_d = LS_LOCKED;
      end
      LS_LOCKED: if (miss_act) state_d = LS_ACQ_M;
      default:   state_d = LS_PWRDN;
    endcase
    if (pwr_dn) state_d = LS_PWRDN;
  end

  always_comb begin
    lane_en    = '0;
    lane_en[0] = (state_q == LS_ACQ_M);
    for (int l = 1; l < LANES; l++) lane_en[l] = (state_q == LS_ACQ_S);
  end

  assign lock_o = (state_q == LS_LOCKED) && !pwr_dn && !miss_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_PWRDN;
      win_q   <= '0;
      qseen_q <= 1'b0;
      quad_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != LS_ACQ_S) begin
        win_q   <= '0;
        qseen_q <= 1'b0;
      end else if (tick) begin
        win_q   <= WW'(win_nx);
        qseen_q <= qseen_nx;
      end
      if (state_q == LS_PWRDN)             quad_q <= 1'b0;
      else if (ev_lock_enter && !pwr_dn)   quad_q <= qseen_nx;
    end
  end

  // R6
  master_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LS_ACQ_S) && tick && !lane_mark[0] && !pwr_dn) |=> (state_q == LS_ACQ_M));

  // R7
  pwr_dn_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (state_q == LS_PWRDN));

  // R5
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LS_LOCKED) && ($past(state_q) == LS_LOCKED)) |-> $stable(quad_q));

  // R3
  fail_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fail && !pwr_dn) |=> (state_q == LS_ACQ_M));

endmodule

// File: rtl/word_gate.sv
module word_gate #(
  parameter int WORD_W = 32
) (
  input  logic              lock,
  input  logic              out_en,
  input  logic              pwr_dn,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  output logic              drive_en
);

  assign word_valid = lock;
  assign word_out   = lock ? word_in : '0;
  assign drive_en   = out_en && !pwr_dn;

endmodule

// File: rtl/lane_lock_ctrl.sv
module lane_lock_ctrl
  import lockctl_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int MASTER_RUN = 8,
  parameter int SEC_RUN    = 4,
  parameter int QUAD_WIN   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              out_en,
  input  logic              frame_tick,
  input  logic [LANES-1:0]  lane_mark,
  input  logic [WORD_W-1:0] rx_word,
  output logic              lock,
  output logic              quad_mode,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_out,
  output logic              out_drive_en
);

  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] done_nxt;
  lk_state_e        state_q;
  logic             ev_fail, ev_lock_enter;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LIM = (g == 0) ? MASTER_RUN : SEC_RUN;
    lane_run_ctr #(.LIMIT(LIM)) u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (lane_en[g]),
      .tick     (frame_tick),
      .mark     (lane_mark[g]),
      .done_nxt (done_nxt[g])
    );
  end

  lock_fsm #(.QUAD_WIN(QUAD_WIN)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_dn        (pwr_dn),
    .tick          (frame_tick),
    .lane_mark     (lane_mark),
    .done_nxt      (done_nxt),
    .state_q       (state_q),
    .lane_en       (lane_en),
    .quad_q        (quad_mode),
    .lock_o        (lock),
    .ev_fail       (ev_fail),
    .ev_lock_enter (ev_lock_enter)
  );

  word_gate #(.WORD_W(WORD_W)) u_gate (
    .lock       (lock),
    .out_en     (out_en),
    .pwr_dn     (pwr_dn),
    .word_in    (rx_word),
    .word_valid (word_valid),
    .word_out   (word_out),
    .drive_en   (out_drive_en)
  );

  // R3
  miss_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == LS_LOCKED) && frame_tick && !lane_mark[0]) |-> !lock);

  // R2
  word_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |-> (word_out == '0));

  // R7
  pd_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (!lock && !out_drive_en));

  // R1
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(ev_lock_enter));

  // R4
  acq_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LS_ACQ_M) |-> !lock);

  // R8
  drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_drive_en |-> out_en);

  // R3
  fail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fail |-> !lock);

endmodule

// File: tb/lane_lock_ctrl_bench.sv
module lane_lock_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_dn = 1'b1;
  logic        out_en = 1'b1;
  logic        frame_tick = 1'b0;
  logic [3:0]  lane_mark = 4'h0;
  logic [31:0] rx_word = 32'h1234_5678;
  logic        lock, quad_mode, word_valid, out_drive_en;
  logic [31:0] word_out;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #4 clk = ~clk;

  lane_lock_ctrl u_lane_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .out_en(out_en),
    .frame_tick(frame_tick), .lane_mark(lane_mark), .rx_word(rx_word),
    .lock(lock), .quad_mode(quad_mode), .word_valid(word_valid),
    .word_out(word_out), .out_drive_en(out_drive_en)
  );

  always @(negedge clk) rx_word = rx_word * 32'd1664525 + 32'd1013904223;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // reference model: 0 idle, 1 master hunt, 2 secondary hunt, 3 locked
  int m_st = 0, m_win = 0, n_st = 0, n_win = 0;
  int m_run[4] = '{0, 0, 0, 0};
  int n_run[4] = '{0, 0, 0, 0};
  bit m_qs = 0, m_mode = 0, n_qs = 0, n_mode = 0;

  always @(negedge clk) begin
    bit          miss, exp_lock;
    logic [3:0]  need;
    int          r[4];
    int          w;
    bit          qs;
    #2;
    need = m_mode ? 4'hF : 4'h3;
    miss = frame_tick && ((need & ~lane_mark) != 4'h0);
    exp_lock = (m_st == 3) && !pwr_dn && !miss;
    chk(lock === exp_lock, "R1 lock", lock, exp_lock);
    chk(word_valid === exp_lock && word_out === (exp_lock ? rx_word : 32'h0),
        "R2 word", word_out, exp_lock ? rx_word : 32'h0);
    chk(quad_mode === m_mode, "R5 mode", quad_mode, m_mode);
    chk(out_drive_en === (out_en && !pwr_dn), "R8 drive", out_drive_en, out_en && !pwr_dn);

    n_st = m_st; n_win = m_win; n_qs = m_qs; n_mode = m_mode;
    for (int l = 0; l < 4; l++) n_run[l] = m_run[l];
    case (m_st)
      0: begin
        n_mode = 0; n_st = 1; n_win = 0; n_qs = 0;
        for (int l = 0; l < 4; l++) n_run[l] = 0;
      end
      1: begin
        for (int l = 1; l < 4; l++) n_run[l] = 0;
        n_win = 0; n_qs = 0;
        if (frame_tick) begin
          n_run[0] = lane_mark[0] ? ((m_run[0] + 1 > 8) ? 8 : m_run[0] + 1) : 0;
          if (lane_mark[0] && m_run[0] + 1 >= 8) n_st = 2;
        end
      end
      2: begin
        n_run[0] = 0;
        if (frame_tick) begin
          for (int l = 1; l < 4; l++) begin
            r[l] = lane_mark[l] ? ((m_run[l] + 1 > 4) ? 4 : m_run[l] + 1) : 0;
            n_run[l] = r[l];
          end
          w = (m_win + 1 > 17) ? 17 : m_win + 1;
          qs = m_qs || (r[2] >= 4 && r[3] >= 4 && w <= 16);
          n_win = w; n_qs = qs;
          if (!lane_mark[0]) n_st = 1;
          else if (r[1] >= 4 && (qs ? (r[2] >= 4 && r[3] >= 4) : (w >= 16))) begin
            n_st = 3;
            if (!pwr_dn) n_mode = qs;
          end
        end
      end
      default: begin
        for (int l = 0; l < 4; l++) n_run[l] = 0;
        n_win = 0; n_qs = 0;
        if (miss) n_st = 1;
      end
    endcase
    if (pwr_dn) n_st = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_win <= 0; m_qs <= 0; m_mode <= 0;
      for (int l = 0; l < 4; l++) m_run[l] <= 0;
    end else begin
      m_st <= n_st; m_win <= n_win; m_qs <= n_qs; m_mode <= n_mode;
      for (int l = 0; l < 4; l++) m_run[l] <= n_run[l];
    end
  end

  task automatic frame(input logic [3:0] m);
    @(negedge clk); frame_tick = 1'b1; lane_mark = m;
    @(negedge clk); frame_tick = 1'b0; lane_mark = ~m;
  endtask

  task automatic frames(input int n, input logic [3:0] m);
    for (int i = 0; i < n; i++) frame(m);
  endtask

  task automatic look(input string req, input bit exp_lock, input bit exp_quad);
    #3;
    chk(lock === exp_lock, req, lock, exp_lock);
    chk(quad_mode === exp_quad, req, quad_mode, exp_quad);
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #3;
    // R10 reset state
    chk(lock === 1'b0 && word_valid === 1'b0, "R10 lock", lock, 0);
    chk(quad_mode === 1'b0, "R10 mode", quad_mode, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b0;

    // R1 R4: all lanes good, lock needs 8 master then 4 secondary ticks
    frames(11, 4'hF);
    look("R4 no lock after 11", 0, 0);
    frame(4'hF);
    look("R1 quad lock at 12", 1, 1);
    frames(3, 4'hF);

    // R3: single miss on lane 3 in quad mode
    @(negedge clk); frame_tick = 1'b1; lane_mark = 4'b0111;
    #3; chk(lock === 1'b0, "R3 same-cycle drop", lock, 0);
    @(negedge clk); frame_tick = 1'b0;
    #3; chk(lock === 1'b0, "R3 stays low", lock, 0);

    // R4: gap in master run restarts the count
    frames(5, 4'hF);
    frame(4'b1110);
    frames(11, 4'hF);
    look("R4 after gap 11", 0, 1);
    frame(4'hF);
    look("R4 after gap 12", 1, 1);

    // R6: master miss during secondary acquisition
    frame(4'h0);
    frames(10, 4'hF);
    frame(4'b1110);
    frames(11, 4'hF);
    look("R6 restart 11", 0, 1);
    frame(4'hF);
    look("R6 restart 12", 1, 1);

    // R5 two-lane: lanes 2,3 never good
    frame(4'h0);
    frames(8, 4'h3);
    frames(15, 4'h3);
    look("R5 dual waits window", 0, 1);
    frame(4'h3);
    look("R5 dual lock at 16", 1, 0);

    // R9: lanes 2,3 ignored in two-lane mode
    frames(5, 4'b0011);
    frame(4'b1011);
    look("R9 dual ignores 2/3", 1, 0);

    // R5 boundary: lanes 2,3 complete exactly on frame 16
    frame(4'h2);
    frames(8, 4'hF);
    frames(12, 4'h3);
    frames(3, 4'hF);
    look("R5 edge not yet", 0, 0);
    frame(4'hF);
    look("R5 quad at frame 16", 1, 1);

    // R5 boundary: completion would land on frame 17
    frame(4'h0);
    frames(8, 4'hF);
    frames(13, 4'h3);
    frames(2, 4'hF);
    look("R5 late not yet", 0, 1);
    frame(4'hF);
    look("R5 dual at frame 16", 1, 0);
    frame(4'hF);
    look("R5 mode held", 1, 0);

    // R8: drive enable follows out_en, lock unaffected
    @(negedge clk); out_en = 1'b0;
    #3; chk(out_drive_en === 1'b0 && lock === 1'b1, "R8 out_en low", out_drive_en, 0);
    @(negedge clk); out_en = 1'b1;

    // R7: power-down together with a missed marker
    @(negedge clk); pwr_dn = 1'b1; frame_tick = 1'b1; lane_mark = 4'b0001;
    #3;
    chk(lock === 1'b0, "R7 lock low", lock, 0);
    chk(out_drive_en === 1'b0, "R7 drive low", out_drive_en, 0);
    @(negedge clk); frame_tick = 1'b0;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b0;
    frames(11, 4'hF);
    look("R7 relock 11", 0, 0);
    frame(4'hF);
    look("R7 relock 12", 1, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule